// File: doc/BRIEF.md
# Graphics Status and Readback Port

This block is the processor-facing register window of a graphics unit. It offers two 32-bit registers on a simple strobe bus. Reading the data register pops one word from a readback queue. The graphics engine fills that queue through a push port. Reading the status register returns a live status word. The status word shows the queue state, the programmed DMA transfer direction, a sticky overflow flag and the current display line parity.

The block also drives a DMA request line. A 2-bit direction field, set through a control write to the status offset, selects the source of that request. A DMA read port drains the queue one word per strobe when the direction is readback-to-processor. In any other direction it returns filler words. Command execution, drawing and display timing belong elsewhere; vertical blank and line parity arrive as inputs.

Top module: `gfx_status_port`

## Requirements
- R1: A read at byte offset 0x00 returns the readback queue head and pops it. A read at 0x04 returns the status word and pops nothing. A read at any other offset returns 0xFFFFFFFF and leaves the queue untouched.
- R2: A read at 0x00 while the queue is empty returns 0xFFFFFFFF and leaves the queue empty.
- R3: The queue returns words in the order they were pushed, and each successful pop removes exactly one word.
- R4: Status bit 31 follows the line_odd input and reads as 0 whenever vblank is high.
- R5: Status bit 27 (ready to send) is 1 when the queue is non-empty. Bits 26 (ready for command) and 28 (ready for DMA) are 1 when it is empty. All three reflect the queue state on the cycle after a push or pop.
- R6: A write to 0x04 whose bits 31:24 equal 0x04 loads the direction from bits 1:0, and status bits 30:29 show it. A write to 0x04 with any other opcode except 0x00 is ignored, and so is any write to 0x00.
- R7: dma_request is 0 for direction 0, 1 for direction 1, equal to status bit 28 for direction 2, and equal to status bit 27 for direction 3. Status bit 25 always equals dma_request.
- R8: A DMA read while the direction is not 3 returns 0xFFFFFFFF and does not pop.
- R9: A DMA read with direction 3 returns the queue head and pops it. When the queue is empty it returns 0x00000000, so a burst longer than the queue yields the stored words followed by zeros.
- R10: After reset the status word reads 0x14802000 (line_odd low), the queue is empty and dma_request is 0.
- R11: The queue holds 16 words. A push into a full queue without a pop in the same cycle is dropped and sets the sticky overflow flag at status bit 15.
- R12: A write to 0x04 with bits 31:24 equal to 0x00 empties the queue, sets the direction to 0 and clears the overflow flag, so the status word returns to 0x14802000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_rd | input | 1 | Register read strobe; data is valid in the same cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| dma_rd | input | 1 | DMA word read strobe |
| dma_rdata | output | 32 | DMA read data |
| dma_request | output | 1 | DMA request selected by the direction field |
| rb_push | input | 1 | Push strobe from the graphics engine into the readback queue |
| rb_push_data | input | 32 | Word to push |
| vblank | input | 1 | Vertical blank active |
| line_odd | input | 1 | Current display line parity |

## Verification
The assertions assume that the register read strobe and the DMA read strobe are never high in the same cycle. A check on the inputs guards this, because the two pop paths share a single queue read. Every bench task releases all strobes at the falling edge before it raises its own, so the stimulus never breaks that rule. The sequences cover an empty-queue read, in-order drain, overflow beyond 16 words, each direction code and a soft clear with data still queued.

// File: rtl/gsp_pkg.sv
// Shared types and constants for the graphics status and readback port.
// Assumes a 32-bit data path; bit positions are fixed by the status layout.
package gsp_pkg;

    localparam int DATA_W = 32;

    // DMA transfer direction codes (the encoding is behaviour, see R7)
    typedef enum logic [1:0] {
        DIR_OFF    = 2'd0,
        DIR_FIFO   = 2'd1,
        DIR_TO_CMD = 2'd2,
        DIR_TO_CPU = 2'd3
    } dma_dir_e;

    // Register byte offsets
    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;

    // Control opcodes carried in bits 31:24 of a write to OFS_STAT
    localparam logic [7:0] OP_SOFT_CLR = 8'h00;
    localparam logic [7:0] OP_SET_DIR  = 8'h04;

    // Status word bit positions
    localparam int BIT_LINE    = 31;
    localparam int BIT_DIR_HI  = 30;
    localparam int BIT_DIR_LO  = 29;
    localparam int BIT_RX_DMA  = 28;
    localparam int BIT_TX_RDY  = 27;
    localparam int BIT_RX_CMD  = 26;
    localparam int BIT_DMA_REQ = 25;
    localparam int BIT_OVF     = 15;

    // Bits of the status word that never change in this block
    localparam logic [DATA_W-1:0] STATIC_BITS = 32'h0080_2000;

    // Filler word for reads with nothing valid to return
    localparam logic [DATA_W-1:0] FILL_ONES = '1;

endpackage

// File: rtl/gsp_fifo.sv
// Readback queue: a circular buffer of DEPTH words with flush.
// Assumes pop is only requested by the decoder when a word is wanted; a pop
// on an empty queue is ignored. A push into a full queue is accepted only if
// a pop happens in the same cycle, otherwise it is dropped and flagged.
module gsp_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             full;
    logic             do_pop;
    logic             do_push;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy flags and accepted operations
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        do_pop  = pop && !empty && !flush;
        do_push = push && !flush && (!full || do_pop);
        drop    = push && !flush && full && !do_pop;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    assign head = mem[rd_ptr];

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop && !flush |=> count == CW'(DEPTH));

    // R3
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !empty && !push && !flush |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/gsp_status.sv
// Status word and DMA request generation.
// Holds the direction field and the sticky overflow flag; everything else in
// the word is derived combinationally from the queue state and inputs.
module gsp_status
    import gsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              dir_wr,
    input  dma_dir_e          dir_wdata,
    input  logic              drop,
    input  logic              empty,
    input  logic              line_odd,
    input  logic              vblank,
    output dma_dir_e          dir,
    output logic [DATA_W-1:0] status_word,
    output logic              dma_req
);
    dma_dir_e dir_q;
    logic     ovf_q;

    // Direction register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) dir_q <= DIR_OFF;
        else if (dir_wr)        dir_q <= dir_wdata;
    end

    // Sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) ovf_q <= 1'b0;
        else if (drop)          ovf_q <= 1'b1;
    end

    // Request source selection by direction
    always_comb begin
        case (dir_q)
            DIR_OFF:    dma_req = 1'b0;
            DIR_FIFO:   dma_req = 1'b1;
            DIR_TO_CMD: dma_req = empty;
            DIR_TO_CPU: dma_req = !empty;
            default:    dma_req = 1'b0;
        endcase
    end

    // Status word assembly
    always_comb begin
        status_word                        = STATIC_BITS;
        status_word[BIT_LINE]              = line_odd && !vblank;
        status_word[BIT_DIR_HI:BIT_DIR_LO] = dir_q;
        status_word[BIT_RX_DMA]            = empty;
        status_word[BIT_TX_RDY]            = !empty;
        status_word[BIT_RX_CMD]            = empty;
        status_word[BIT_DMA_REQ]           = dma_req;
        status_word[BIT_OVF]               = ovf_q;
    end

    assign dir = dir_q;

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !soft_clr |=> ovf_q);

    // R12
    clr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> dir_q == DIR_OFF && !ovf_q);

endmodule

// File: rtl/gsp_decode.sv
// Register and DMA access decoder.
// Assumes reg_rd and dma_rd are never high together; selects read data,
// produces the queue pop and decodes control writes to the status offset.
module gsp_decode
    import gsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              dma_rd,
    input  dma_dir_e          dir,
    input  logic              empty,
    input  logic [DATA_W-1:0] head,
    input  logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              fifo_pop,
    output logic              soft_clr,
    output logic              dir_wr,
    output dma_dir_e          dir_wdata
);
    logic       sel_data;
    logic       sel_stat;
    logic [7:0] opcode;
    logic       dma_live;
    logic       unused_wdata;

    assign sel_data     = (reg_addr == ADDR_W'(OFS_DATA));
    assign sel_stat     = (reg_addr == ADDR_W'(OFS_STAT));
    assign opcode       = reg_wdata[31:24];
    assign dma_live     = (dir == DIR_TO_CPU);
    assign unused_wdata = ^reg_wdata[23:2];

    // Register read data selection
    always_comb begin
        if (sel_data)      reg_rdata = empty ? FILL_ONES : head;
        else if (sel_stat) reg_rdata = status_word;
        else               reg_rdata = FILL_ONES;
    end

    // DMA read data selection
    always_comb begin
        if (!dma_live)  dma_rdata = FILL_ONES;
        else if (empty) dma_rdata = '0;
        else            dma_rdata = head;
    end

    // Queue pop from either read path
    always_comb begin
        fifo_pop = !empty && ((reg_rd && sel_data) || (dma_rd && dma_live));
    end

    // Control write decode
    always_comb begin
        soft_clr  = reg_wr && sel_stat && (opcode == OP_SOFT_CLR);
        dir_wr    = reg_wr && sel_stat && (opcode == OP_SET_DIR);
        dir_wdata = dma_dir_e'(reg_wdata[1:0]);
    end

endmodule

// File: rtl/gfx_status_port.sv
// Top of the graphics status and readback port.
// Connects the readback queue, status generator and access decoder.
// Assumes reg_rd and dma_rd are never asserted in the same cycle.
module gfx_status_port
    import gsp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int RB_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dma_rd,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              dma_request,
    input  logic              rb_push,
    input  logic [DATA_W-1:0] rb_push_data,
    input  logic              vblank,
    input  logic              line_odd
);
    logic              empty;
    logic              drop;
    logic              fifo_pop;
    logic              soft_clr;
    logic              dir_wr;
    dma_dir_e          dir_wdata;
    dma_dir_e          dir;
    logic [DATA_W-1:0] head;
    logic [DATA_W-1:0] status_word;

    gsp_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (RB_DEPTH)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_clr),
        .push      (rb_push),
        .push_data (rb_push_data),
        .pop       (fifo_pop),
        .head      (head),
        .empty     (empty),
        .drop      (drop)
    );

    gsp_status status_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_clr    (soft_clr),
        .dir_wr      (dir_wr),
        .dir_wdata   (dir_wdata),
        .drop        (drop),
        .empty       (empty),
        .line_odd    (line_odd),
        .vblank      (vblank),
        .dir         (dir),
        .status_word (status_word),
        .dma_req     (dma_request)
    );

    gsp_decode #(
        .ADDR_W (ADDR_W)
    ) decode_i (
        .reg_addr    (reg_addr),
        .reg_rd      (reg_rd),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .dma_rd      (dma_rd),
        .dir         (dir),
        .empty       (empty),
        .head        (head),
        .status_word (status_word),
        .reg_rdata   (reg_rdata),
        .dma_rdata   (dma_rdata),
        .fifo_pop    (fifo_pop),
        .soft_clr    (soft_clr),
        .dir_wr      (dir_wr),
        .dir_wdata   (dir_wdata)
    );

    // input assumption: the two read paths never pop in the same cycle
    one_reader_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && dma_rd));

    // R2
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == ADDR_W'(OFS_DATA) && empty && !rb_push
        |=> empty);

    // R4
    vblank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank && reg_addr == ADDR_W'(OFS_STAT) |-> !reg_rdata[BIT_LINE]);

    // R7
    req_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == ADDR_W'(OFS_STAT) |-> reg_rdata[BIT_DMA_REQ] == dma_request);

    // R8
    dma_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd && !(reg_rdata[BIT_DIR_HI] && reg_rdata[BIT_DIR_LO])
        && reg_addr == ADDR_W'(OFS_STAT) |-> dma_rdata == FILL_ONES);

    // R9
    dma_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_request && reg_addr == ADDR_W'(OFS_STAT)
        && reg_rdata[BIT_DIR_HI] && reg_rdata[BIT_DIR_LO]
        |-> reg_rdata[BIT_TX_RDY]);

endmodule

// File: tb/gfx_status_port_tb_top.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor pops and
// compares it shortly after each falling edge while a read strobe is high.
module gfx_status_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [7:0]  reg_addr;
    logic        reg_rd;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        dma_rd;
    logic [31:0] dma_rdata;
    logic        dma_request;
    logic        rb_push;
    logic [31:0] rb_push_data;
    logic        vblank;
    logic        line_odd;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_d[$];
    string       exp_t[$];
    bit          done = 0;

    gfx_status_port dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_rd       (reg_rd),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .dma_rd       (dma_rd),
        .dma_rdata    (dma_rdata),
        .dma_request  (dma_request),
        .rb_push      (rb_push),
        .rb_push_data (rb_push_data),
        .vblank       (vblank),
        .line_odd     (line_odd)
    );

    initial clk = 0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data against the scoreboard
    always @(negedge clk) begin
        #2;
        if (reg_rd || dma_rd) begin
            if (exp_d.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL scoreboard: actual %08h expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_d.pop_front();
                t = exp_t.pop_front();
                compare(reg_rd ? reg_rdata : dma_rdata, e, t);
            end
        end
    end

    task automatic clr();
        reg_rd = 0; reg_wr = 0; dma_rd = 0; rb_push = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk); clr();
        reg_addr = a; reg_rd = 1;
        exp_d.push_back(e); exp_t.push_back(t);
    endtask

    task automatic drd(input logic [31:0] e, input string t);
        @(negedge clk); clr();
        reg_addr = 8'h10; dma_rd = 1;
        exp_d.push_back(e); exp_t.push_back(t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); clr();
        reg_addr = a; reg_wdata = d; reg_wr = 1;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); clr();
        rb_push = 1; rb_push_data = d;
    endtask

    task automatic chk_req(input logic e, input string t);
        @(negedge clk); clr();
        #2;
        compare({31'd0, dma_request}, {31'd0, e}, t);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
            $finish;
        end
    end

    // Stimulus
    initial begin
        clr();
        reg_addr = 0; reg_wdata = 0; rb_push_data = 0;
        vblank = 0; line_odd = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10 reset state
        rd(8'h04, 32'h1480_2000, "R10 reset status");
        chk_req(1'b0, "R10 reset request");

        // R2 empty read
        rd(8'h00, 32'hFFFF_FFFF, "R2 empty read");
        rd(8'h04, 32'h1480_2000, "R2 still empty");

        // R1 undecoded offsets
        rd(8'h08, 32'hFFFF_FFFF, "R1 offset 08");
        rd(8'h0C, 32'hFFFF_FFFF, "R1 offset 0C");

        // R3 / R5 order and flags
        push(32'hA000_0001);
        push(32'hB000_0002);
        push(32'hC000_0003);
        rd(8'h04, 32'h0880_2000, "R5 non-empty flags");
        rd(8'h08, 32'hFFFF_FFFF, "R1 no pop on bad offset");
        rd(8'h00, 32'hA000_0001, "R1 head word");
        rd(8'h00, 32'hB000_0002, "R3 second word");
        rd(8'h00, 32'hC000_0003, "R3 third word");
        rd(8'h04, 32'h1480_2000, "R5 empty flags after drain");

        // R4 line parity and vblank mask
        @(negedge clk); clr(); line_odd = 1;
        rd(8'h04, 32'h9480_2000, "R4 line bit");
        @(negedge clk); clr(); vblank = 1;
        rd(8'h04, 32'h1480_2000, "R4 vblank mask");
        @(negedge clk); clr(); vblank = 0; line_odd = 0;

        // R6 / R7 direction 1
        wr(8'h04, 32'h0400_0001);
        rd(8'h04, 32'h3680_2000, "R6 dir 1 status");
        chk_req(1'b1, "R7 dir 1 request");
        wr(8'h04, 32'h0500_0003);
        wr(8'h00, 32'h0400_0003);
        rd(8'h04, 32'h3680_2000, "R6 ignored writes");

        // R7 direction 2
        wr(8'h04, 32'h0400_0002);
        rd(8'h04, 32'h5680_2000, "R7 dir 2 empty");
        chk_req(1'b1, "R7 dir 2 request empty");
        push(32'hD000_0004);
        rd(8'h04, 32'h4880_2000, "R7 dir 2 non-empty");
        chk_req(1'b0, "R7 dir 2 request busy");

        // R7 direction 3
        wr(8'h04, 32'h0400_0003);
        rd(8'h04, 32'h6A80_2000, "R7 dir 3 status");
        chk_req(1'b1, "R7 dir 3 request");

        // R9 DMA burst longer than the queue
        push(32'hE000_0005);
        drd(32'hD000_0004, "R9 dma word 1");
        drd(32'hE000_0005, "R9 dma word 2");
        drd(32'h0000_0000, "R9 dma zero fill");
        chk_req(1'b0, "R7 dir 3 request drained");

        // R8 DMA read in the wrong direction
        wr(8'h04, 32'h0400_0002);
        push(32'hF000_0006);
        drd(32'hFFFF_FFFF, "R8 dma filler 1");
        drd(32'hFFFF_FFFF, "R8 dma filler 2");
        rd(8'h00, 32'hF000_0006, "R8 no pop");

        // R11 overflow
        wr(8'h04, 32'h0400_0000);
        for (int i = 0; i < 17; i++) push(32'h100 + i);
        rd(8'h04, 32'h0880_A000, "R11 overflow flag");
        for (int i = 0; i < 16; i++) rd(8'h00, 32'h100 + i, "R11 drain order");
        rd(8'h00, 32'hFFFF_FFFF, "R11 extra word dropped");
        rd(8'h04, 32'h1480_A000, "R11 flag sticky");

        // R12 soft clear
        wr(8'h04, 32'h0400_0003);
        push(32'h7777_0007);
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, 32'h1480_2000, "R12 status cleared");
        rd(8'h00, 32'hFFFF_FFFF, "R12 queue cleared");
        chk_req(1'b0, "R12 request cleared");

        @(negedge clk); clr();
        repeat (2) @(negedge clk);
        done = 1;
        report();
        $finish;
    end

endmodule